// File: doc/BRIEF.md
# Race-Free Flow-Table Sequencer

This block is a clocked model of a two-input fundamental-mode flow table with five named states (R, A, B, C, D). The encoding is chosen so that every transition between neighbouring states flips a single state bit. Each rising clock edge samples the two inputs, X and Y, and applies one hop of the next-state function. A transition that would otherwise need two bits to change at once is routed through an intermediate transient state. As a result, the machine moves one bit per edge until it arrives at a state whose table entry holds it.

Besides the state code, the block produces three registered flags. The first says the entry just applied kept the state where it was, meaning the state is stable. The second says X and Y both changed between two consecutive samples, which the flow table forbids. The third says the entry just applied is unspecified in the table. The reset code is a parameter so that a system can start the machine in any legal state. The default is R.

Top module: `fts_sequencer`

## Requirements
- R1: A synchronous active-high reset loads the state code with RESET_CODE (default 3'b000) and clears stable, illegal_input and dont_care.
- R2: The state codes are R=3'b000, A=3'b001, D=3'b010, C=3'b011 and B=3'b101. Only these five codes ever appear on state_code.
- R3: On every clock edge where the state code changes, exactly one of its bits changes.
- R4: From R, inputs XY=00 or XY=11 hold R and XY=01 moves to A. From A, XY=00 or XY=01 hold A, XY=10 moves to B, and XY=11 moves to R. X is the high bit of XY.
- R5: From D, XY=00 or XY=10 hold D, XY=01 moves to C, and XY=11 moves to R. From C, XY=01 holds C, XY=00 moves to A, and XY=11 moves to D.
- R6: Unspecified entries are B with XY=01, B with XY=11, and C with XY=10. On such an entry the state is held, dont_care is high for that edge, and stable is low. From B, XY=10 holds B and XY=00 moves to A.
- R7: From R with XY=10, the first edge moves to A as a transient state and the second edge moves on to B.
- R8: After each edge, stable is high exactly when the entry applied on that edge was a specified hold of the present state.
- R9: illegal_input is high after an edge whose sample differs from the previous sample in both X and Y. The table is still applied to the new sample. The first sample after reset never raises the flag.
- R10: When the inputs are held after a single-input change, the state code reaches its final value within two edges, and stable is high by the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_x | input | 1 | Flow-table input X (high bit of XY) |
| in_y | input | 1 | Flow-table input Y (low bit of XY) |
| state_code | output | 3 | Present state code |
| stable | output | 1 | The last applied entry held the state |
| illegal_input | output | 1 | Both inputs changed since the previous sample |
| dont_care | output | 1 | The last applied entry is unspecified |

## Verification
If the state register holds a wrong code, it appears on state_code at the very next edge. The stable flag then disagrees with the expected hold or move on the edge after that. A wrong hop that jumps two bits is visible in a single cycle as a double-bit difference between consecutive state codes. A wrong previous-input register shows up on illegal_input one edge after the stimulus. Two instances are run side by side, one reset into R and one into D, so that the C/D half of the table, which cannot be reached from R, is also exercised at the ports.

// File: rtl/fts_pkg.sv
package fts_pkg;

    localparam int STATE_W = 3;
    localparam int IN_W    = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_R  = 3'b000,
        ST_A  = 3'b001,
        ST_D  = 3'b010,
        ST_C  = 3'b011,
        ST_U4 = 3'b100,
        ST_B  = 3'b101,
        ST_U6 = 3'b110,
        ST_U7 = 3'b111
    } fts_code_e;

    typedef struct packed {
        fts_code_e          state;
        logic [IN_W-1:0]    xy_prev;
        logic               xy_valid;
        logic               stable;
        logic               illegal;
        logic               dcare;
    } fts_regs_t;

endpackage

// File: rtl/fts_hop_table.sv
module fts_hop_table
    import fts_pkg::*;
(
    input  fts_code_e          state_i,
    input  logic [IN_W-1:0]    xy_i,
    output fts_code_e          next_o,
    output logic               dc_o
);

    always_comb begin
        next_o = state_i;
        dc_o   = 1'b0;
        unique case (state_i)
            ST_R: begin
                case (xy_i)
                    2'b01:   next_o = ST_A;
                    2'b10:   next_o = ST_A;   // transient step on the way to B
                    default: next_o = ST_R;
                endcase
            end
            ST_A: begin
                case (xy_i)
                    2'b10:   next_o = ST_B;
                    2'b11:   next_o = ST_R;
                    default: next_o = ST_A;
                endcase
            end
            ST_B: begin
                case (xy_i)
                    2'b00:   next_o = ST_A;
                    2'b10:   next_o = ST_B;
                    default: dc_o   = 1'b1;
                endcase
            end
            ST_C: begin
                case (xy_i)
                    2'b00:   next_o = ST_A;
                    2'b01:   next_o = ST_C;
                    2'b11:   next_o = ST_D;
                    default: dc_o   = 1'b1;
                endcase
            end
            ST_D: begin
                case (xy_i)
                    2'b01:   next_o = ST_C;
                    2'b11:   next_o = ST_R;
                    default: next_o = ST_D;
                endcase
            end
            // unused codes step one bit toward a legal neighbour
            ST_U4:   next_o = ST_R;
            ST_U6:   next_o = ST_D;
            ST_U7:   next_o = ST_C;
            default: next_o = ST_R;
        endcase
    end

endmodule

// File: rtl/fts_pair_watch.sv
module fts_pair_watch
    import fts_pkg::*;
(
    input  logic [IN_W-1:0] prev_i,
    input  logic [IN_W-1:0] cur_i,
    input  logic            valid_i,
    output logic            double_o
);

    logic [IN_W-1:0] diff;

    always_comb begin
        diff     = prev_i ^ cur_i;
        double_o = valid_i && (diff == {IN_W{1'b1}});
    end

endmodule

// File: rtl/fts_sequencer.sv
module fts_sequencer
    import fts_pkg::*;
#(
    parameter logic [2:0] RESET_CODE = 3'b000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_x,
    input  logic       in_y,
    output logic [2:0] state_code,
    output logic       stable,
    output logic       illegal_input,
    output logic       dont_care
);

    fts_regs_t       regs_d, regs_q;
    fts_code_e       hop_next;
    logic            hop_dc;
    logic            pair_double;
    logic [IN_W-1:0] xy;

    assign xy = {in_x, in_y};

    fts_hop_table u_table (
        .state_i (regs_q.state),
        .xy_i    (xy),
        .next_o  (hop_next),
        .dc_o    (hop_dc)
    );

    fts_pair_watch u_watch (
        .prev_i   (regs_q.xy_prev),
        .cur_i    (xy),
        .valid_i  (regs_q.xy_valid),
        .double_o (pair_double)
    );

    always_comb begin
        regs_d          = regs_q;
        regs_d.state    = hop_next;
        regs_d.stable   = (hop_next == regs_q.state) && !hop_dc;
        regs_d.dcare    = hop_dc;
        regs_d.illegal  = pair_double;
        regs_d.xy_prev  = xy;
        regs_d.xy_valid = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.state    <= fts_code_e'(RESET_CODE);
            regs_q.xy_prev  <= '0;
            regs_q.xy_valid <= 1'b0;
            regs_q.stable   <= 1'b0;
            regs_q.illegal  <= 1'b0;
            regs_q.dcare    <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_code    = regs_q.state;
    assign stable        = regs_q.stable;
    assign illegal_input = regs_q.illegal;
    assign dont_care     = regs_q.dcare;

endmodule

// File: rtl/fts_sequencer_chk.sv
module fts_sequencer_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_x,
    input logic       in_y,
    input logic [2:0] state_code,
    input logic       stable,
    input logic       illegal_input,
    input logic       dont_care
);

    // R3
    one_bit_hop_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code != $past(state_code)) |->
            ($countones(state_code ^ $past(state_code)) == 1));

    // R2
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code != 3'b100) && (state_code != 3'b110) && (state_code != 3'b111));

    // R6
    dont_care_hold_chk: assert property (@(posedge clk) disable iff (rst)
        dont_care |-> ((state_code == $past(state_code)) && !stable));

    // R8
    stable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stable |-> (state_code == $past(state_code)));

    // R9
    illegal_cause_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_input |-> (($past(in_x) != $past(in_x, 2)) && ($past(in_y) != $past(in_y, 2))));

endmodule

bind fts_sequencer fts_sequencer_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_x          (in_x),
    .in_y          (in_y),
    .state_code    (state_code),
    .stable        (stable),
    .illegal_input (illegal_input),
    .dont_care     (dont_care)
);

// File: tb/fts_sequencer_bench.sv
module fts_sequencer_bench;

    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_x = 1'b0;
    logic in_y = 1'b0;

    logic [2:0] st0, st1;
    logic stb0, stb1, ill0, ill1, dc0, dc1;

    always #(PERIOD/2) clk = ~clk;

    fts_sequencer u_fts_sequencer (
        .clk (clk), .rst (rst), .in_x (in_x), .in_y (in_y),
        .state_code (st0), .stable (stb0), .illegal_input (ill0), .dont_care (dc0)
    );

    fts_sequencer #(.RESET_CODE(3'b010)) u_fts_sequencer_alt (
        .clk (clk), .rst (rst), .in_x (in_x), .in_y (in_y),
        .state_code (st1), .stable (stb1), .illegal_input (ill1), .dont_care (dc1)
    );

    typedef struct packed {
        logic [2:0] st;
        logic       stb;
        logic       ill;
        logic       dc;
    } exp_t;

    typedef struct {
        exp_t  e0;
        exp_t  e1;
        string tag;
    } item_t;

    item_t q[$];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [2:0] m0, m1;         // model states
    logic [1:0] m_prev;
    bit         m_valid;
    logic [2:0] last0, last1;   // last observed state codes

    // Table from the requirements: returns {dc, next}
    function automatic logic [3:0] ref_hop(input logic [2:0] s, input logic [1:0] xy);
        case (s)
            3'b000: return (xy == 2'b01 || xy == 2'b10) ? 4'b0_001 : 4'b0_000;
            3'b001: return (xy == 2'b10) ? 4'b0_101 : (xy == 2'b11) ? 4'b0_000 : 4'b0_001;
            3'b101: return (xy == 2'b10) ? 4'b0_101 : (xy == 2'b00) ? 4'b0_001 : {1'b1, s};
            3'b011: return (xy == 2'b01) ? 4'b0_011 : (xy == 2'b00) ? 4'b0_001 :
                           (xy == 2'b11) ? 4'b0_010 : {1'b1, s};
            3'b010: return (xy == 2'b01) ? 4'b0_011 : (xy == 2'b11) ? 4'b0_000 : 4'b0_010;
            default: return 4'b0_000;
        endcase
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    function automatic exp_t model_step(inout logic [2:0] s, input logic [1:0] xy, input logic ill);
        exp_t       e;
        logic [3:0] h;
        h     = ref_hop(s, xy);
        e.st  = h[2:0];
        e.dc  = h[3];
        e.stb = (h[2:0] == s) && !h[3];
        e.ill = ill;
        s     = h[2:0];
        return e;
    endfunction

    // driver: drive at a falling edge, queue the expectation, wait one cycle
    task automatic step(input logic x, input logic y, input string tag);
        item_t it;
        logic  ill;
        in_x = x;
        in_y = y;
        ill  = m_valid && ((m_prev ^ {x, y}) == 2'b11);
        it.e0  = model_step(m0, {x, y}, ill);
        it.e1  = model_step(m1, {x, y}, ill);
        it.tag = tag;
        m_prev  = {x, y};
        m_valid = 1'b1;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst  = 1'b1;
        in_x = 1'b0;
        in_y = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check({5'd0, st0}, {5'd0, 3'b000}, "R1 state main");
        check({5'd0, st1}, {5'd0, 3'b010}, "R1 state alt");
        check({2'd0, stb0, ill0, dc0, stb1, ill1, dc1}, 8'd0, "R1 flags");
        m0 = 3'b000; m1 = 3'b010; m_prev = 2'b00; m_valid = 1'b0;
        last0 = 3'b000; last1 = 3'b010;
        rst = 1'b0;
    endtask

    // monitor: compares a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (!rst && q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check({5'd0, st0}, {5'd0, it.e0.st}, {it.tag, " state main"});
                check({5'd0, st1}, {5'd0, it.e1.st}, {it.tag, " state alt"});
                check({5'd0, stb0, ill0, dc0}, {5'd0, it.e0.stb, it.e0.ill, it.e0.dc}, {it.tag, " flags main"});
                check({5'd0, stb1, ill1, dc1}, {5'd0, it.e1.stb, it.e1.ill, it.e1.dc}, {it.tag, " flags alt"});
                // R3: any change flips one bit
                if (st0 != last0) check({7'd0, $countones(st0 ^ last0) == 1}, 8'd1, "R3 main");
                if (st1 != last1) check({7'd0, $countones(st1 ^ last1) == 1}, 8'd1, "R3 alt");
                last0 = st0;
                last1 = st1;
            end
        end
    end

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        step(0, 0, "R8");
        step(0, 1, "R4 R5");
        step(0, 1, "R8");
        step(1, 1, "R4 R5");
        step(1, 1, "R5");
        step(1, 0, "R7");
        step(1, 0, "R7");
        step(1, 0, "R10");
        step(1, 1, "R6");
        step(0, 1, "R6");
        step(0, 0, "R6");
        step(0, 0, "R8");
        step(1, 1, "R9");
        step(0, 0, "R9");
        step(0, 1, "R4");
        step(0, 1, "R10");

        do_reset();
        step(0, 1, "R9 first R5");
        step(1, 0, "R9 R6");
        step(1, 0, "R6");
        step(1, 1, "R5");
        step(1, 0, "R5");
        step(0, 0, "R5");
        step(0, 1, "R5");
        step(0, 1, "R10");
        step(0, 0, "R5");
        step(0, 0, "R10");

        do_reset();
        step(1, 1, "R9 first");
        step(1, 1, "R8");

        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule